// File: doc/BRIEF.md
# Ping-Pong Bulk Endpoint Buffer Arbiter

This block decides, for one unidirectional bulk endpoint, which of two packet buffers the USB transaction engine may use and which one belongs to the CPU. Ownership is held in two one-bit flags. A hardware flag names the buffer the engine works on. A software flag names the buffer the CPU is working on. When the two flags differ, the engine's buffer is free: the next token gets an ACK and the transfer proceeds. When the flags are equal, the engine's next buffer is still held by the CPU, so the token gets a NAK and the host retries later. Each completed transfer inverts the hardware flag. Each CPU release strobe inverts the software flag. The CPU can therefore drain one buffer while the host fills the other, and the host is refused only when both buffers are busy.

The buffer layout comes from four 16-bit descriptor entries that are supplied as inputs. In double-buffer mode the transmit-side address/count pair is buffer 0 and the receive-side pair is buffer 1, both used in the endpoint's one direction. In single-buffer mode the token direction picks the pair instead: IN uses the transmit pair and OUT uses the receive pair. On an accepted token the block returns the chosen buffer's address and length together with the descriptor byte offset. On an OUT completion it issues a one-cycle write of the received byte count to the correct count entry.

Top module: `pingpong_ep_arb`

## Requirements
- R1: Synchronous active-high reset clears both flags, the open-transfer state, hs_valid and cnt_wr_en. The first token after reset is answered with NAK (hs_ack=0).
- R2: Every cycle with xact_start=1 produces hs_valid=1 exactly one cycle later, and every other cycle leaves hs_valid=0. hs_ack=1 (ACK) only if, at the token, hw_flag differed from sw_flag, no transfer was open, and the direction check of R8 passed. Otherwise hs_ack=0 (NAK).
- R3: A cycle with cpu_flip=1 inverts sw_flag, visible one cycle later.
- R4: xact_done while a transfer is open closes it and inverts hw_flag one cycle later. xact_done with no open transfer leaves hw_flag unchanged and writes nothing.
- R5: In double-buffer mode (dbl_mode=1), an accepted token uses buffer 0 (tx_addr_ent, low LW bits of tx_cnt_ent, desc_off = 8·EP_IDX) when hw_flag=0, and buffer 1 (rx_addr_ent, low LW bits of rx_cnt_ent, desc_off = 8·EP_IDX+4) when hw_flag=1. These values appear together with hs_valid.
- R6: In single-buffer mode (dbl_mode=0), an IN token (xact_is_in=1) uses the transmit pair and an OUT token uses the receive pair, whatever the value of hw_flag.
- R7: Closing an OUT transfer raises cnt_wr_en for exactly one cycle, one cycle after xact_done. cnt_wr_off is 8·EP_IDX+2 for the transmit pair or 8·EP_IDX+6 for the receive pair, and cnt_wr_data is xact_rx_cnt zero-extended. Closing an IN transfer writes nothing.
- R8: In double-buffer mode, a token whose direction differs from ep_is_in gets a NAK and changes no state.
- R9: A token that arrives while a transfer is open gets a NAK, and the open transfer still completes normally.
- R10: When the host sends tokens faster than the CPU releases buffers, the number of ACKs equals the number of cpu_flip strobes, with NAKs in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbl_mode | input | 1 | 1 = double-buffer mode, 0 = single-buffer mode |
| ep_is_in | input | 1 | Endpoint direction in double-buffer mode (1 = IN) |
| tx_addr_ent | input | AW | Descriptor entry: transmit-side buffer address |
| tx_cnt_ent | input | AW | Descriptor entry: transmit-side count |
| rx_addr_ent | input | AW | Descriptor entry: receive-side buffer address |
| rx_cnt_ent | input | AW | Descriptor entry: receive-side count |
| xact_start | input | 1 | Token strobe from the transaction engine |
| xact_is_in | input | 1 | Token direction (1 = IN) |
| xact_done | input | 1 | Transfer-complete strobe |
| xact_rx_cnt | input | LW | Received byte count, valid with xact_done |
| cpu_flip | input | 1 | CPU release strobe, inverts the software flag |
| hs_valid | output | 1 | Handshake valid, one cycle after a token |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| buf_addr | output | AW | Packet buffer address of the accepted token |
| buf_len | output | LW | Packet buffer length of the accepted token |
| desc_off | output | OW | Byte offset of the address entry in use |
| cnt_wr_en | output | 1 | Count write-back strobe |
| cnt_wr_off | output | OW | Byte offset of the count entry to write |
| cnt_wr_data | output | AW | Count value to write |
| hw_flag | output | 1 | Buffer currently owned by the engine |
| sw_flag | output | 1 | Buffer currently owned by the CPU |

## Verification
The bench builds the block with EP_IDX=3, so every descriptor offset it checks (24, 26, 28, 30) depends on the endpoint stride and not only on the entry position. It keeps AW=16 and LW=10 and loads a transmit count entry with set upper bits, which shows that only the low LW bits reach buf_len. The vector walk models a host that sends tokens faster than the CPU releases buffers. Directed sequences then switch between IN and OUT endpoints and between the two buffering modes, with each flag combination set up before the token that tests it.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // Entry order inside one endpoint's descriptor block; neighbours decode it.
  typedef enum logic [1:0] {
    ENT_TX_ADDR = 2'd0,
    ENT_TX_CNT  = 2'd1,
    ENT_RX_ADDR = 2'd2,
    ENT_RX_CNT  = 2'd3
  } ent_e;

  localparam int ENT_BYTES = 2;
  localparam int EP_STRIDE = 4 * ENT_BYTES;

  function automatic int ent_off(input int ep, input ent_e e);
    return ep * EP_STRIDE + int'(e) * ENT_BYTES;
  endfunction
endpackage

// File: rtl/ppa_flags.sv
module ppa_flags (
  input  logic clk,
  input  logic rst,
  input  logic cpu_flip,
  input  logic adv,
  output logic hw_flag,
  output logic sw_flag,
  output logic free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hw_flag <= 1'b0;
      sw_flag <= 1'b0;
    end else begin
      if (adv)      hw_flag <= ~hw_flag;
      if (cpu_flip) sw_flag <= ~sw_flag;
    end
  end

  // Equal flags: engine's next buffer still held by the CPU.
  assign free = hw_flag ^ sw_flag;
endmodule

// File: rtl/ppa_bufsel.sv
module ppa_bufsel #(
  parameter int AW = 16,
  parameter int LW = 10
) (
  input  logic          dbl_mode,
  input  logic          ep_is_in,
  input  logic          is_in,
  input  logic          hw_flag,
  input  logic [AW-1:0] tx_addr_ent,
  input  logic [AW-1:0] tx_cnt_ent,
  input  logic [AW-1:0] rx_addr_ent,
  input  logic [AW-1:0] rx_cnt_ent,
  output logic          sel_rx,
  output logic          dir_ok,
  output logic [AW-1:0] sel_addr,
  output logic [LW-1:0] sel_len
);
  always_comb begin
    sel_rx   = dbl_mode ? hw_flag : ~is_in;
    dir_ok   = !dbl_mode || (is_in == ep_is_in);
    sel_addr = sel_rx ? rx_addr_ent : tx_addr_ent;
    sel_len  = sel_rx ? rx_cnt_ent[LW-1:0] : tx_cnt_ent[LW-1:0];
  end
endmodule

// File: rtl/ppa_xact.sv
module ppa_xact
  import ppa_pkg::*;
#(
  parameter int AW     = 16,
  parameter int LW     = 10,
  parameter int OW     = 8,
  parameter int EP_IDX = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_in,
  input  logic          done,
  input  logic [LW-1:0] rx_cnt,
  input  logic          dir_ok,
  input  logic          free,
  input  logic          sel_rx,
  input  logic [AW-1:0] sel_addr,
  input  logic [LW-1:0] sel_len,
  output logic          adv,
  output logic          xfer_open,
  output logic          hs_valid,
  output logic          hs_ack,
  output logic [AW-1:0] buf_addr,
  output logic [LW-1:0] buf_len,
  output logic [OW-1:0] desc_off,
  output logic          cnt_wr_en,
  output logic [OW-1:0] cnt_wr_off,
  output logic [AW-1:0] cnt_wr_data
);
  localparam logic [OW-1:0] OFF_TXA = OW'(ent_off(EP_IDX, ENT_TX_ADDR));
  localparam logic [OW-1:0] OFF_TXC = OW'(ent_off(EP_IDX, ENT_TX_CNT));
  localparam logic [OW-1:0] OFF_RXA = OW'(ent_off(EP_IDX, ENT_RX_ADDR));
  localparam logic [OW-1:0] OFF_RXC = OW'(ent_off(EP_IDX, ENT_RX_CNT));

  logic accept;
  logic cur_rx;
  logic cur_in;

  assign accept = start && free && dir_ok && !xfer_open;
  assign adv    = done && xfer_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_open   <= 1'b0;
      cur_rx      <= 1'b0;
      cur_in      <= 1'b0;
      hs_valid    <= 1'b0;
      hs_ack      <= 1'b0;
      buf_addr    <= '0;
      buf_len     <= '0;
      desc_off    <= '0;
      cnt_wr_en   <= 1'b0;
      cnt_wr_off  <= '0;
      cnt_wr_data <= '0;
    end else begin
      hs_valid  <= start;
      hs_ack    <= accept;
      cnt_wr_en <= adv && !cur_in;
      if (accept) begin
        xfer_open <= 1'b1;
        cur_rx    <= sel_rx;
        cur_in    <= is_in;
        buf_addr  <= sel_addr;
        buf_len   <= sel_len;
        desc_off  <= sel_rx ? OFF_RXA : OFF_TXA;
      end else if (adv) begin
        xfer_open <= 1'b0;
      end
      if (adv) begin
        cnt_wr_off  <= cur_rx ? OFF_RXC : OFF_TXC;
        cnt_wr_data <= {{(AW-LW){1'b0}}, rx_cnt};
      end
    end
  end
endmodule

// File: rtl/pingpong_ep_arb.sv
module pingpong_ep_arb #(
  parameter int AW     = 16,
  parameter int LW     = 10,
  parameter int OW     = 8,
  parameter int EP_IDX = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbl_mode,
  input  logic          ep_is_in,
  input  logic [AW-1:0] tx_addr_ent,
  input  logic [AW-1:0] tx_cnt_ent,
  input  logic [AW-1:0] rx_addr_ent,
  input  logic [AW-1:0] rx_cnt_ent,
  input  logic          xact_start,
  input  logic          xact_is_in,
  input  logic          xact_done,
  input  logic [LW-1:0] xact_rx_cnt,
  input  logic          cpu_flip,
  output logic          hs_valid,
  output logic          hs_ack,
  output logic [AW-1:0] buf_addr,
  output logic [LW-1:0] buf_len,
  output logic [OW-1:0] desc_off,
  output logic          cnt_wr_en,
  output logic [OW-1:0] cnt_wr_off,
  output logic [AW-1:0] cnt_wr_data,
  output logic          hw_flag,
  output logic          sw_flag
);
  logic          adv;
  logic          free;
  logic          xfer_open;
  logic          sel_rx;
  logic          dir_ok;
  logic [AW-1:0] sel_addr;
  logic [LW-1:0] sel_len;

  ppa_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .cpu_flip (cpu_flip),
    .adv      (adv),
    .hw_flag  (hw_flag),
    .sw_flag  (sw_flag),
    .free     (free)
  );

  ppa_bufsel #(.AW(AW), .LW(LW)) u_sel (
    .dbl_mode    (dbl_mode),
    .ep_is_in    (ep_is_in),
    .is_in       (xact_is_in),
    .hw_flag     (hw_flag),
    .tx_addr_ent (tx_addr_ent),
    .tx_cnt_ent  (tx_cnt_ent),
    .rx_addr_ent (rx_addr_ent),
    .rx_cnt_ent  (rx_cnt_ent),
    .sel_rx      (sel_rx),
    .dir_ok      (dir_ok),
    .sel_addr    (sel_addr),
    .sel_len     (sel_len)
  );

  ppa_xact #(.AW(AW), .LW(LW), .OW(OW), .EP_IDX(EP_IDX)) u_xact (
    .clk         (clk),
    .rst         (rst),
    .start       (xact_start),
    .is_in       (xact_is_in),
    .done        (xact_done),
    .rx_cnt      (xact_rx_cnt),
    .dir_ok      (dir_ok),
    .free        (free),
    .sel_rx      (sel_rx),
    .sel_addr    (sel_addr),
    .sel_len     (sel_len),
    .adv         (adv),
    .xfer_open   (xfer_open),
    .hs_valid    (hs_valid),
    .hs_ack      (hs_ack),
    .buf_addr    (buf_addr),
    .buf_len     (buf_len),
    .desc_off    (desc_off),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_off  (cnt_wr_off),
    .cnt_wr_data (cnt_wr_data)
  );
endmodule

// File: rtl/ppa_chk.sv
module ppa_chk (
  input logic clk,
  input logic rst,
  input logic dbl_mode,
  input logic ep_is_in,
  input logic xact_start,
  input logic xact_is_in,
  input logic xact_done,
  input logic cpu_flip,
  input logic hs_valid,
  input logic hs_ack,
  input logic hw_flag,
  input logic sw_flag,
  input logic cnt_wr_en,
  input logic xfer_open
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hs_valid && !cnt_wr_en && !hw_flag && !sw_flag));

  assert_hs_follows_R2: assert property (@(posedge clk) disable iff (rst)
    xact_start |=> hs_valid);

  assert_hs_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !xact_start |=> !hs_valid);

  assert_ack_needs_free_R2: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_ack) |-> $past(hw_flag != sw_flag));

  assert_sw_flip_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_flip |=> (sw_flag != $past(sw_flag)));

  assert_hw_adv_R4: assert property (@(posedge clk) disable iff (rst)
    (xact_done && xfer_open) |=> (hw_flag != $past(hw_flag)));

  assert_hw_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(xact_done && xfer_open) |=> $stable(hw_flag));

  assert_wr_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_en |-> $past(xact_done && xfer_open));

  assert_dir_match_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_ack && $past(dbl_mode)) |-> $past(xact_is_in == ep_is_in));

  assert_busy_nak_R9: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && $past(xfer_open)) |-> !hs_ack);
endmodule

bind pingpong_ep_arb ppa_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dbl_mode   (dbl_mode),
  .ep_is_in   (ep_is_in),
  .xact_start (xact_start),
  .xact_is_in (xact_is_in),
  .xact_done  (xact_done),
  .cpu_flip   (cpu_flip),
  .hs_valid   (hs_valid),
  .hs_ack     (hs_ack),
  .hw_flag    (hw_flag),
  .sw_flag    (sw_flag),
  .cnt_wr_en  (cnt_wr_en),
  .xfer_open  (xfer_open)
);

// File: tb/pingpong_ep_arb_test.sv
`timescale 1ns/1ps
module pingpong_ep_arb_test;
  localparam int AW   = 16;
  localparam int LW   = 10;
  localparam int OW   = 8;
  localparam int EP   = 3;
  localparam int BASE = EP * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dbl_mode = 1'b1;
  logic          ep_is_in = 1'b1;
  logic [AW-1:0] tx_addr_ent = 16'h0040;
  logic [AW-1:0] tx_cnt_ent  = 16'hFC40;
  logic [AW-1:0] rx_addr_ent = 16'h0080;
  logic [AW-1:0] rx_cnt_ent  = 16'h0033;
  logic          xact_start = 1'b0;
  logic          xact_is_in = 1'b0;
  logic          xact_done = 1'b0;
  logic [LW-1:0] xact_rx_cnt = '0;
  logic          cpu_flip = 1'b0;
  logic          hs_valid, hs_ack, cnt_wr_en, hw_flag, sw_flag;
  logic [AW-1:0] buf_addr, cnt_wr_data;
  logic [LW-1:0] buf_len;
  logic [OW-1:0] desc_off, cnt_wr_off;

  int checks = 0;
  int failures = 0;
  int acks = 0;
  int flips = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pingpong_ep_arb #(.AW(AW), .LW(LW), .OW(OW), .EP_IDX(EP)) uut (.*);

  // {flip, start, is_in, done, exp_hs_valid, exp_ack, exp_hw, exp_sw}
  // Host outpaces the CPU on a double-buffered IN endpoint.
  localparam logic [7:0] VEC [15] = '{
    8'b0110_1000, // token right after reset: NAK
    8'b1000_0001, // CPU releases
    8'b0110_1101, // ACK on buffer 0
    8'b0110_1001, // token while open: NAK (R9)
    8'b0001_0011, // done
    8'b0110_1011, // both busy: NAK
    8'b0110_1011, // NAK again
    8'b1000_0010, // CPU releases
    8'b0110_1110, // ACK on buffer 1
    8'b0001_0000, // done
    8'b0110_1000, // NAK
    8'b1000_0001, // CPU releases
    8'b0110_1101, // ACK
    8'b0001_0011, // done
    8'b0001_0011  // stray done ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic s, input logic i, input logic d,
                     input logic [LW-1:0] rc);
    cpu_flip = f; xact_start = s; xact_is_in = i; xact_done = d; xact_rx_cnt = rc;
    @(posedge clk); #1;
    cpu_flip = 1'b0; xact_start = 1'b0; xact_done = 1'b0;
    if (hs_valid && hs_ack) acks++;
    if (f) flips++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1 hw_flag", 32'(hw_flag), 0);
    chk("R1 sw_flag", 32'(sw_flag), 0);
    chk("R1 hs_valid", 32'(hs_valid), 0);
    chk("R1 cnt_wr_en", 32'(cnt_wr_en), 0);

    for (int k = 0; k < 15; k++) begin
      cyc(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], '0);
      chk((k == 3) ? "R9 ack" : (k == 0) ? "R1 ack" : "R2 ack", 32'(hs_ack & hs_valid), 32'(VEC[k][2]));
      chk("R2 hs_valid", 32'(hs_valid), 32'(VEC[k][3]));
      chk("R4 hw_flag", 32'(hw_flag), 32'(VEC[k][1]));
      chk("R3 sw_flag", 32'(sw_flag), 32'(VEC[k][0]));
    end
    chk("R10 acks vs flips", 32'(acks), 32'(flips));
    chk("R10 ack total", 32'(acks), 3);

    // R5: double mode, flags 1/1 now
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 1, 0, '0);
    chk("R5 ack buf1", 32'(hs_ack), 1);
    chk("R5 addr buf1", 32'(buf_addr), 32'h0080);
    chk("R5 len buf1", 32'(buf_len), 32'h033);
    chk("R5 off buf1", 32'(desc_off), BASE + 4);
    cyc(0, 0, 0, 1, '0);
    chk("R4 hw after done", 32'(hw_flag), 0);
    chk("R7 no write on IN", 32'(cnt_wr_en), 0);
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 1, 0, '0);
    chk("R5 addr buf0", 32'(buf_addr), 32'h0040);
    chk("R5 len buf0 masked", 32'(buf_len), 32'h040);
    chk("R5 off buf0", 32'(desc_off), BASE);
    cyc(0, 0, 0, 1, '0);

    // R8: wrong-direction token on IN endpoint
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
    chk("R8 hs_valid", 32'(hs_valid), 1);
    chk("R8 nak", 32'(hs_ack), 0);
    cyc(0, 0, 0, 1, '0);
    chk("R8 hw unchanged", 32'(hw_flag), 1);
    chk("R8 no write", 32'(cnt_wr_en), 0);
    cyc(0, 1, 1, 0, '0);
    chk("R8 right dir ack", 32'(hs_ack), 1);
    cyc(0, 0, 0, 1, '0);

    // R7: OUT endpoint count write-back
    ep_is_in = 1'b0;
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
    chk("R7 ack", 32'(hs_ack), 1);
    chk("R7 off buf0", 32'(desc_off), BASE);
    cyc(0, 0, 0, 1, 10'd37);
    chk("R7 wr_en", 32'(cnt_wr_en), 1);
    chk("R7 wr_off buf0", 32'(cnt_wr_off), BASE + 2);
    chk("R7 wr_data", 32'(cnt_wr_data), 37);
    cyc(0, 0, 0, 0, '0);
    chk("R7 wr pulse ends", 32'(cnt_wr_en), 0);
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
    chk("R7 off buf1", 32'(desc_off), BASE + 4);
    cyc(0, 0, 0, 1, 10'd5);
    chk("R7 wr_off buf1", 32'(cnt_wr_off), BASE + 6);
    chk("R7 wr_data buf1", 32'(cnt_wr_data), 5);

    // R6: single-buffer mode, flags 0/0
    dbl_mode = 1'b0;
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 1, 0, '0);
    chk("R6 IN addr", 32'(buf_addr), 32'h0040);
    cyc(0, 0, 0, 1, '0);
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 1, 0, '0);
    chk("R6 IN ack with hw=1", 32'(hs_ack), 1);
    chk("R6 IN tx pair with hw=1", 32'(desc_off), BASE);
    cyc(0, 0, 0, 1, '0);
    cyc(1, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, '0);
    chk("R6 OUT rx pair with hw=0", 32'(buf_addr), 32'h0080);
    chk("R6 OUT off", 32'(desc_off), BASE + 4);
    cyc(0, 0, 0, 1, 10'd9);
    chk("R6 OUT wr_off", 32'(cnt_wr_off), BASE + 6);
    chk("R6 OUT wr_data", 32'(cnt_wr_data), 9);

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 hw after reset", 32'(hw_flag), 0);
    chk("R1 sw after reset", 32'(sw_flag), 0);
    rst = 1'b0; dbl_mode = 1'b1; ep_is_in = 1'b1;
    cyc(0, 1, 1, 0, '0);
    chk("R1 nak after reset", 32'(hs_ack), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule